// File: doc/BRIEF.md
# Configurable Look-Up Table Logic Slice

The block is a small programmable logic cell with two 4-input look-up tables. Each table keeps a 16-bit truth table. It can act as a logic function of its four inputs, or as a 16x1 memory that is written on the clock edge and read combinationally from the same four inputs. Each table output drives a storage element. That element works either as an edge-triggered flip-flop or as a level-sensitive latch, and a per-table select chooses between the stored value and the raw table output.

The truth tables and mode bits are loaded one bit per clock through a serial configuration chain. The full configuration word is 38 bits. Bit k of the word is the k-th bit shifted in:
- bits [15:0] are the first truth table, where bit j is the output for input value j;
- bits [31:16] are the second truth table;
- bits [34:32] are the mode of the first table;
- bits [37:35] are the mode of the second table.

Within each 3-bit mode group:
- bit 0 selects the stored output (1) or the direct output (0);
- bit 1 selects latch storage (1) or flip-flop storage (0);
- bit 2 enables memory mode.

Top module: `lut_slice`

## Requirements
- R1: While cfg_en_i is high, each rising clock edge shifts cfg_din_i into the chain. After 38 shifts, the k-th bit shifted in occupies bit k of the configuration word laid out as above. While cfg_en_i is low, the configuration holds.
- R2: While cfg_en_i is high, out_o is 0.
- R3: With mode bit 0 clear, out_o[n] equals bit a of truth table n, where a is lut_in_i[4n+3:4n].
- R4: In stored, flip-flop mode, out_o[n] equals the table value sampled at the preceding rising edge, and does not follow input changes between edges.
- R5: In stored, latch mode, out_o[n] follows the table value while clk_i is high, and holds the value present at the falling edge while clk_i is low.
- R6: In memory mode, with wr_en_i high and cfg_en_i low at a rising edge, bit a of the table takes wr_data_i[n]. A combinational read of address a returns the new value right after that edge.
- R7: A table is not changed by wr_en_i low, and a table whose memory-mode bit is clear ignores wr_en_i.
- R8: srst_i high at a rising edge clears both storage elements. A latch is also held at 0 while clk_i is high and srst_i is high. Truth tables and modes are left unchanged.
- R9: rst_ni low clears the configuration and both storage elements at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the latch enable (transparent while high) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Synchronous clear of the storage elements |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_din_i | input | 1 | Configuration serial data |
| lut_in_i | input | 8 | Table inputs, 4 bits per table, table 0 in the low nibble |
| wr_en_i | input | 1 | Memory-mode write enable |
| wr_data_i | input | 2 | Memory-mode write data, one bit per table |
| out_o | output | 2 | Slice outputs, one per table |

## Verification
The properties assume that the mode bits change only through the configuration chain or the reset. They also assume that table inputs and write data are stable around each rising edge, and that the latch property is sampled at the falling edge after a high phase. The stimulus changes inputs only in the low clock phase. The one exception is the deliberate high-phase change that tells latch storage apart from flip-flop storage, and it is made where no rising-edge property samples it. The sweeps cover all 256 input pairs for the direct output and every memory address for writes.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  localparam int MODE_W = 3;
  typedef struct packed {
    logic ram_en;    // bit 2
    logic latch_en;  // bit 1
    logic reg_sel;   // bit 0
  } slice_mode_t;
endpackage

// File: rtl/slice_cfg_chain.sv
module slice_cfg_chain
  import lut_slice_pkg::*;
#(
  parameter int N_LUTS = 2,
  parameter int K      = 4,
  localparam int TT    = 1 << K,
  localparam int W     = N_LUTS * (TT + MODE_W)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_en_i,
  input  logic                         cfg_din_i,
  input  logic [N_LUTS-1:0][K-1:0]     addr_i,
  input  logic                         wr_en_i,
  input  logic [N_LUTS-1:0]            wr_data_i,
  output logic [N_LUTS-1:0][TT-1:0]    tt_o,
  output slice_mode_t [N_LUTS-1:0]     mode_o
);
  logic [W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else if (cfg_en_i) begin
      chain_q <= {cfg_din_i, chain_q[W-1:1]};
    end else if (wr_en_i) begin
      for (int l = 0; l < N_LUTS; l++) begin
        if (mode_o[l].ram_en) chain_q[l*TT + int'(addr_i[l])] <= wr_data_i[l];
      end
    end
  end

  for (genvar l = 0; l < N_LUTS; l++) begin : g_fields
    assign tt_o[l]   = chain_q[l*TT +: TT];
    assign mode_o[l] = slice_mode_t'(chain_q[N_LUTS*TT + l*MODE_W +: MODE_W]);
  end
endmodule

// File: rtl/slice_lut_read.sv
module slice_lut_read #(
  parameter int K   = 4,
  localparam int TT = 1 << K
) (
  input  logic [TT-1:0] tt_i,
  input  logic [K-1:0]  addr_i,
  output logic          f_o
);
  assign f_o = tt_i[addr_i];
endmodule

// File: rtl/slice_store.sv
module slice_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic cfg_en_i,
  input  logic d_i,
  input  logic latch_en_i,
  input  logic reg_sel_i,
  output logic q_o
);
  logic ff_q, lat_q, stored;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ff_q <= 1'b0;
    else if (srst_i) ff_q <= 1'b0;
    else             ff_q <= d_i;
  end

  // transparent while clock high
  always_latch begin
    if (!rst_ni)     lat_q <= 1'b0;
    else if (clk_i)  lat_q <= srst_i ? 1'b0 : d_i;
  end

  assign stored = latch_en_i ? lat_q : ff_q;
  assign q_o    = cfg_en_i ? 1'b0 : (reg_sel_i ? stored : d_i);
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
#(
  parameter int N_LUTS = 2,
  parameter int K      = 4,
  localparam int TT    = 1 << K
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  srst_i,
  input  logic                  cfg_en_i,
  input  logic                  cfg_din_i,
  input  logic [N_LUTS*K-1:0]   lut_in_i,
  input  logic                  wr_en_i,
  input  logic [N_LUTS-1:0]     wr_data_i,
  output logic [N_LUTS-1:0]     out_o
);
  logic [N_LUTS-1:0][K-1:0]  addr;
  logic [N_LUTS-1:0][TT-1:0] tt;
  slice_mode_t [N_LUTS-1:0]  mode;
  logic [N_LUTS-1:0]         f;

  assign addr = lut_in_i;

  slice_cfg_chain #(.N_LUTS(N_LUTS), .K(K)) u_cfg (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_din_i,
    .addr_i(addr), .wr_en_i, .wr_data_i,
    .tt_o(tt), .mode_o(mode)
  );

  for (genvar l = 0; l < N_LUTS; l++) begin : g_cell
    slice_lut_read #(.K(K)) u_rd (.tt_i(tt[l]), .addr_i(addr[l]), .f_o(f[l]));
    slice_store u_st (
      .clk_i, .rst_ni, .srst_i, .cfg_en_i,
      .d_i(f[l]), .latch_en_i(mode[l].latch_en), .reg_sel_i(mode[l].reg_sel),
      .q_o(out_o[l])
    );
  end
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk
  import lut_slice_pkg::*;
#(
  parameter int N_LUTS = 2,
  parameter int K      = 4,
  localparam int TT    = 1 << K
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      srst_i,
  input logic                      cfg_en_i,
  input logic                      wr_en_i,
  input logic [N_LUTS-1:0]         wr_data_i,
  input logic [N_LUTS-1:0]         out_o,
  input logic [N_LUTS-1:0][K-1:0]  addr,
  input logic [N_LUTS-1:0][TT-1:0] tt,
  input slice_mode_t [N_LUTS-1:0]  mode
);
  AST_CFG_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> out_o == '0); // R2

  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_i && !wr_en_i) |=> $stable(tt)); // R7

  AST_SRST_KEEPS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_i && !cfg_en_i && !wr_en_i) |=> ($stable(tt) && $stable(mode))); // R8

  for (genvar l = 0; l < N_LUTS; l++) begin : g_chk
    AST_DIRECT_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_en_i && !mode[l].reg_sel) |-> out_o[l] == tt[l][addr[l]]); // R3

    AST_FF_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_en_i && !srst_i && mode[l].reg_sel && !mode[l].latch_en)
      |=> (cfg_en_i || out_o[l] == $past(tt[l][addr[l]]))); // R4

    AST_LATCH_HOLD: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!cfg_en_i && !srst_i && mode[l].reg_sel && mode[l].latch_en)
      |-> out_o[l] == tt[l][addr[l]]); // R5

    AST_RAM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_en_i && wr_en_i && mode[l].ram_en)
      |=> tt[l][$past(addr[l])] == $past(wr_data_i[l])); // R6

    AST_LOGIC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_en_i && !mode[l].ram_en) |=> $stable(tt[l])); // R7

    AST_SRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> (cfg_en_i || !mode[l].reg_sel || mode[l].latch_en || out_o[l] == 1'b0)); // R8
  end
endmodule

bind lut_slice lut_slice_chk #(.N_LUTS(N_LUTS), .K(K)) u_chk (
  .clk_i, .rst_ni, .srst_i, .cfg_en_i, .wr_en_i, .wr_data_i, .out_o,
  .addr, .tt, .mode
);

// File: tb/lut_slice_test.sv
module lut_slice_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic [7:0] lut_in = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_data = '0;
  logic [1:0] out;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lut_slice uut (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .cfg_en_i(cfg_en),
    .cfg_din_i(cfg_din), .lut_in_i(lut_in), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .out_o(out)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // mode = {ram, latch, reg_sel}
  function automatic logic [37:0] mk(logic [15:0] t0, logic [15:0] t1,
                                     logic [2:0] m0, logic [2:0] m1);
    return {m1, m0, t1, t0};
  endfunction

  task automatic load(input logic [37:0] w);
    for (int i = 0; i < 38; i++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_din = w[i];
      #1 chk("R2", out, 2'b00);
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  logic [15:0] t0, t1, pat;

  initial begin
    #3 chk("R9", out, 2'b00);
    #20 rst_n = 1'b1;

    // R1 R3: direct output, full sweep
    t0 = 16'hA5C3; t1 = 16'h6E19;
    load(mk(t0, t1, 3'b000, 3'b000));
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        lut_in = {4'(b), 4'(a)};
        #1 chk("R1_R3", out, {t1[b], t0[a]});
      end
    end

    // R4 (table 0 flip-flop) and R5 (table 1 latch)
    t0 = 16'h37D2; t1 = 16'hB14E;
    load(mk(t0, t1, 3'b001, 3'b011));
    for (int a = 0; a < 16; a++) begin
      int a2, b2;
      @(negedge clk);
      lut_in = {4'(15 - a), 4'(a)};
      @(posedge clk);
      #1 chk("R4_R5 edge", out, {t1[15 - a], t0[a]});
      a2 = (a + 5) % 16; b2 = (a + 9) % 16;
      lut_in = {4'(b2), 4'(a2)};
      #1 chk("R4_R5 high phase", out, {t1[b2], t0[a]});
      @(negedge clk);
      lut_in = {4'(b2 ^ 3), 4'(a2 ^ 3)};
      #1 chk("R4_R5 low hold", out, {t1[b2], t0[a]});
    end

    // R8: clear storage, contents kept
    @(negedge clk);
    lut_in = {4'd2, 4'd1};
    srst = 1'b1;
    @(posedge clk);
    #1 chk("R8 clear", out, 2'b00);
    @(negedge clk);
    srst = 1'b0;
    #1 chk("R8 latch low", out, 2'b00);
    @(posedge clk);
    #1 chk("R8 kept", out, {t1[2], t0[1]});

    // R6 R7: table 0 memory, table 1 logic
    t1 = 16'h5A0F; pat = 16'h9C63;
    load(mk(16'h0000, t1, 3'b100, 3'b000));
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      lut_in = {4'(a), 4'(a)};
      wr_en = 1'b1;
      wr_data = {~t1[a], pat[a]};
      @(posedge clk);
      #1 chk("R6 read after write", out, {t1[a], pat[a]});
    end
    @(negedge clk);
    wr_en = 1'b0;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      lut_in = {4'(15 - a), 4'(a)};
      wr_data = {t1[15 - a], ~pat[a]};
      @(posedge clk);
      #1 chk("R6_R7 readback", out, {t1[15 - a], pat[a]});
    end

    // R9: async reset clears configuration and storage
    load(mk(16'hFFFF, 16'hFFFF, 3'b001, 3'b000));
    @(negedge clk);
    chk("R9 preset", out, 2'b11);
    #1 rst_n = 1'b0;
    #1 chk("R9 async", out, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a += 5) begin
      @(negedge clk);
      lut_in = {4'(a), 4'(a)};
      @(posedge clk);
      #1 chk("R9 cleared", out, 2'b00);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule